// File: doc/BRIEF.md
# Upset Test Page Sequencer

This block runs the repeating test loop used to expose a processor under test to single-event upsets while a known pattern sits in one of its registers. It owns the processor's reset and non-maskable interrupt lines. It also owns the page select of an undecoded, paged program memory. Each loop does four things in turn. First it resets the processor, which then loads a pattern and halts. Next it waits for the processor's shutdown acknowledge. It then replaces every fetch with halt opcodes for a configurable soak time. Finally it restores the test page, wakes the processor with a short NMI pulse and waits for the readback to be seen. After that the loop starts again.

The program memory has no address decoding. The word address is the 7-bit page number followed by processor address bits [9:2]. Because of this, one 1 KB page repeats across the whole 4 GB space. The reset fetch at FFFFFFF0h and the NMI vector read at 00000008h therefore fall in the same page. The test page is taken from its configuration input only while the processor is held in reset. The all-halt override applies only while the processor is halted.

The states are RESET, LOAD, SOAK, RESTORE, NMI, READBACK and ABORT. Each transition is listed below:
- RESET to LOAD after the reset time.
- LOAD to SOAK on the acknowledge.
- LOAD to ABORT when the wait expires.
- SOAK to RESTORE after the soak time.
- RESTORE to NMI after one cycle.
- NMI to READBACK after the pulse.
- READBACK to RESET on the readback strobe.
- READBACK to ABORT when the wait expires.
- ABORT to RESET after one cycle.

Top module: `upset_page_seq`

## Requirements
- R1: While rst_n is low, and for exactly 8 cycles at the start of every loop, dut_reset is 1 and dut_nmi, halt_active and timeout_pulse are 0.
- R2: After the reset phase the block waits with all control outputs low for dut_shutdown_ack. An acknowledge seen in any of the first cfg_ack_timeout+1 cycles, including the last one, starts the soak in the next cycle.
- R3: If no acknowledge comes in that window, timeout_pulse is 1 for exactly one cycle, and then an 8-cycle reset phase begins.
- R4: halt_active is 1 for exactly cfg_soak_cycles+1 cycles. While it is 1, dut_rdata is F4F4F4F4h whatever mem_rdata holds. Otherwise dut_rdata equals mem_rdata.
- R5: After the soak comes exactly one cycle with all control outputs low, and then dut_nmi is 1 for exactly 4 cycles.
- R6: After the NMI pulse the block waits for readback_strobe for up to cfg_ack_timeout+1 cycles. A strobe starts a reset phase in the next cycle. With no strobe, the R3 timeout sequence follows.
- R7: mem_addr equals {page_sel, dut_addr[9:2]}. dut_addr FFFFFFF0h gives word offset FCh and dut_addr 00000008h gives offset 02h, both within the same page.
- R8: page_sel takes cfg_test_page only during the reset phase. A change to cfg_test_page at any other time shows only after the next reset phase.
- R9: dut_shutdown_ack outside LOAD and readback_strobe outside READBACK have no effect on any output or on the length of any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_test_page | input | 7 | Program page for the next loop |
| cfg_soak_cycles | input | 24 | Soak length minus one, sampled when the acknowledge is taken |
| cfg_ack_timeout | input | 24 | Wait window minus one for acknowledge and readback |
| dut_shutdown_ack | input | 1 | Processor has entered shutdown |
| readback_strobe | input | 1 | Readback of the register under test was observed |
| dut_addr | input | 32 | Processor byte address |
| mem_rdata | input | 32 | Data from the paged program memory |
| dut_reset | output | 1 | Reset to the processor |
| dut_nmi | output | 1 | Non-maskable interrupt to the processor |
| page_sel | output | 7 | Page currently mapped |
| mem_addr | output | 15 | Word address into program memory |
| dut_rdata | output | 32 | Read data returned to the processor |
| halt_active | output | 1 | All-halt override is active (soak) |
| timeout_pulse | output | 1 | One-cycle flag of an aborted loop |

## Verification
Loops are run with the acknowledge in the first cycle of its window and in the last, with no acknowledge at all, and with no readback strobe. This separates an accepted handshake from one off by a cycle, and each abort path from the normal loop. Stray acknowledges and strobes are injected during reset, soak and load, and these show whether a handshake is obeyed outside its own state. The read data is probed during and outside the soak, which tells the halt override apart from the memory path. The reset and NMI addresses, together with a page change made mid-loop, tell whether the page is captured only in reset.

// File: rtl/upset_seq_pkg.sv
package upset_seq_pkg;
    typedef enum logic [2:0] {
        ST_RESET,
        ST_LOAD,
        ST_SOAK,
        ST_RESTORE,
        ST_NMI,
        ST_READBACK,
        ST_ABORT
    } seq_state_t;
endpackage

// File: rtl/upset_seq_timer.sv
module upset_seq_timer #(
    parameter int CNT_W = 24,
    parameter int INIT  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= INIT_V;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/upset_seq_fsm.sv
module upset_seq_fsm
    import upset_seq_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int RST_LEN = 8,
    parameter int NMI_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shutdown_ack,
    input  logic             readback_strobe,
    input  logic [CNT_W-1:0] cfg_soak,
    input  logic [CNT_W-1:0] cfg_timeout,
    input  logic             tmr_expired,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             dut_reset,
    output logic             dut_nmi,
    output logic             halt_active,
    output logic             timeout_pulse,
    output logic             page_capture
);
    localparam logic [CNT_W-1:0] RST_TC = CNT_W'(RST_LEN - 1);
    localparam logic [CNT_W-1:0] NMI_TC = CNT_W'(NMI_LEN - 1);

    seq_state_t state_q, state_d;

    // next state and phase timer reload
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_RESET: begin
                if (tmr_expired) begin
                    state_d  = ST_LOAD;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_timeout;
                end
            end
            ST_LOAD: begin
                if (shutdown_ack) begin
                    state_d  = ST_SOAK;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_soak;
                end else if (tmr_expired) begin
                    state_d = ST_ABORT;
                end
            end
            ST_SOAK: begin
                if (tmr_expired) begin
                    state_d = ST_RESTORE;
                end
            end
            ST_RESTORE: begin
                state_d  = ST_NMI;
                tmr_load = 1'b1;
                tmr_val  = NMI_TC;
            end
            ST_NMI: begin
                if (tmr_expired) begin
                    state_d  = ST_READBACK;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_timeout;
                end
            end
            ST_READBACK: begin
                if (readback_strobe) begin
                    state_d  = ST_RESET;
                    tmr_load = 1'b1;
                    tmr_val  = RST_TC;
                end else if (tmr_expired) begin
                    state_d = ST_ABORT;
                end
            end
            ST_ABORT: begin
                state_d  = ST_RESET;
                tmr_load = 1'b1;
                tmr_val  = RST_TC;
            end
            default: begin
                state_d  = ST_RESET;
                tmr_load = 1'b1;
                tmr_val  = RST_TC;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore outputs
    always_comb begin
        dut_reset     = 1'b0;
        dut_nmi       = 1'b0;
        halt_active   = 1'b0;
        timeout_pulse = 1'b0;
        page_capture  = 1'b0;
        unique case (state_q)
            ST_RESET: begin
                dut_reset    = 1'b1;
                page_capture = 1'b1;
            end
            ST_SOAK:     halt_active   = 1'b1;
            ST_NMI:      dut_nmi       = 1'b1;
            ST_ABORT:    timeout_pulse = 1'b1;
            ST_LOAD, ST_RESTORE, ST_READBACK: begin
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/upset_page_path.sv
module upset_page_path #(
    parameter int          PAGE_W    = 7,
    parameter int          OFS_W     = 8,
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter logic [7:0]  HALT_BYTE = 8'hF4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    capture,
    input  logic [PAGE_W-1:0]       cfg_page,
    input  logic                    halt_active,
    input  logic [ADDR_W-1:0]       dut_addr,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic [PAGE_W-1:0]       page_sel,
    output logic [PAGE_W+OFS_W-1:0] mem_addr,
    output logic [DATA_W-1:0]       dut_rdata
);
    localparam int LANES  = DATA_W / 8;
    localparam int LANE_B = (LANES > 1) ? $clog2(LANES) : 1;

    logic [PAGE_W-1:0] page_q;
    logic [DATA_W-1:0] halt_word;
    logic              unused_addr_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (capture) begin
            page_q <= cfg_page;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_halt_lane
        assign halt_word[g*8 +: 8] = HALT_BYTE;
    end

    // undecoded: upper address bits are dropped, page wraps over the space
    assign mem_addr  = {page_q, dut_addr[OFS_W+LANE_B-1:LANE_B]};
    assign page_sel  = page_q;
    assign dut_rdata = halt_active ? halt_word : mem_rdata;

    assign unused_addr_bits = ^{dut_addr[ADDR_W-1:OFS_W+LANE_B], dut_addr[LANE_B-1:0]};
endmodule

// File: rtl/upset_page_seq.sv
module upset_page_seq #(
    parameter int PAGE_W  = 7,
    parameter int OFS_W   = 8,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 24,
    parameter int RST_LEN = 8,
    parameter int NMI_LEN = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PAGE_W-1:0]       cfg_test_page,
    input  logic [CNT_W-1:0]        cfg_soak_cycles,
    input  logic [CNT_W-1:0]        cfg_ack_timeout,
    input  logic                    dut_shutdown_ack,
    input  logic                    readback_strobe,
    input  logic [ADDR_W-1:0]       dut_addr,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    dut_reset,
    output logic                    dut_nmi,
    output logic [PAGE_W-1:0]       page_sel,
    output logic [PAGE_W+OFS_W-1:0] mem_addr,
    output logic [DATA_W-1:0]       dut_rdata,
    output logic                    halt_active,
    output logic                    timeout_pulse
);
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             page_capture;

    upset_seq_timer #(
        .CNT_W (CNT_W),
        .INIT  (RST_LEN - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    upset_seq_fsm #(
        .CNT_W   (CNT_W),
        .RST_LEN (RST_LEN),
        .NMI_LEN (NMI_LEN)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .shutdown_ack    (dut_shutdown_ack),
        .readback_strobe (readback_strobe),
        .cfg_soak        (cfg_soak_cycles),
        .cfg_timeout     (cfg_ack_timeout),
        .tmr_expired     (tmr_expired),
        .tmr_load        (tmr_load),
        .tmr_val         (tmr_val),
        .dut_reset       (dut_reset),
        .dut_nmi         (dut_nmi),
        .halt_active     (halt_active),
        .timeout_pulse   (timeout_pulse),
        .page_capture    (page_capture)
    );

    upset_page_path #(
        .PAGE_W (PAGE_W),
        .OFS_W  (OFS_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (page_capture),
        .cfg_page    (cfg_test_page),
        .halt_active (halt_active),
        .dut_addr    (dut_addr),
        .mem_rdata   (mem_rdata),
        .page_sel    (page_sel),
        .mem_addr    (mem_addr),
        .dut_rdata   (dut_rdata)
    );
endmodule

// File: rtl/upset_page_seq_sva.sv
module upset_page_seq_sva #(
    parameter int PAGE_W  = 7,
    parameter int NMI_LEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dut_reset,
    input logic              dut_nmi,
    input logic              halt_active,
    input logic              timeout_pulse,
    input logic              dut_shutdown_ack,
    input logic              readback_strobe,
    input logic [PAGE_W-1:0] page_sel
);
    logic [7:0] nmi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_run <= '0;
        end else if (dut_nmi) begin
            if (nmi_run != 8'hFF) nmi_run <= nmi_run + 8'd1;
        end else begin
            nmi_run <= '0;
        end
    end

    a_r1_exclusive_controls: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dut_reset, dut_nmi, halt_active, timeout_pulse}));

    a_r2_soak_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_active) |-> $past(dut_shutdown_ack));

    a_r3_timeout_then_reset: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> dut_reset);

    a_r5_restore_then_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_active) |=> dut_nmi);

    a_r5_nmi_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dut_nmi) |-> (nmi_run == 8'(NMI_LEN)));

    a_r6_reset_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dut_reset) |-> ($past(timeout_pulse) || $past(readback_strobe)));

    a_r8_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        !dut_reset |=> $stable(page_sel));
endmodule

bind upset_page_seq upset_page_seq_sva #(
    .PAGE_W  (PAGE_W),
    .NMI_LEN (NMI_LEN)
) u_sva (
    .clk              (clk),
    .rst_n            (rst_n),
    .dut_reset        (dut_reset),
    .dut_nmi          (dut_nmi),
    .halt_active      (halt_active),
    .timeout_pulse    (timeout_pulse),
    .dut_shutdown_ack (dut_shutdown_ack),
    .readback_strobe  (readback_strobe),
    .page_sel         (page_sel)
);

// File: tb/upset_page_seq_tb.sv
module upset_page_seq_tb;
    localparam int P_RST = 0, P_IDLE = 1, P_SOAK = 2, P_NMI = 3, P_ABORT = 4;

    typedef struct {
        int    ph;
        int    len;
        string req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  cfg_test_page = 7'h2A;
    logic [23:0] cfg_soak_cycles = 24'd5;
    logic [23:0] cfg_ack_timeout = 24'd6;
    logic        dut_shutdown_ack = 1'b0;
    logic        readback_strobe = 1'b0;
    logic [31:0] dut_addr = 32'h0;
    logic [31:0] mem_rdata = 32'hA5A5_0F0F;
    logic        dut_reset, dut_nmi, halt_active, timeout_pulse;
    logic [6:0]  page_sel;
    logic [14:0] mem_addr;
    logic [31:0] dut_rdata;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 1'b0;
    item_t exp_q[$];
    logic [6:0] cur_page = 7'h2A;

    always #10 clk = ~clk;

    upset_page_seq u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_test_page (cfg_test_page),
        .cfg_soak_cycles (cfg_soak_cycles), .cfg_ack_timeout (cfg_ack_timeout),
        .dut_shutdown_ack (dut_shutdown_ack), .readback_strobe (readback_strobe),
        .dut_addr (dut_addr), .mem_rdata (mem_rdata), .dut_reset (dut_reset),
        .dut_nmi (dut_nmi), .page_sel (page_sel), .mem_addr (mem_addr),
        .dut_rdata (dut_rdata), .halt_active (halt_active), .timeout_pulse (timeout_pulse)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int ph, input int len, input string req);
        item_t it;
        it.ph = ph; it.len = len; it.req = req;
        exp_q.push_back(it);
    endtask

    // monitor: measure phase runs and compare with the expected queue
    int cur_ph = P_RST;
    int run_len = 0;
    bit skip_first = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            int ph;
            ph = dut_reset ? P_RST : dut_nmi ? P_NMI : halt_active ? P_SOAK :
                 timeout_pulse ? P_ABORT : P_IDLE;
            if (ph == cur_ph) begin
                run_len++;
            end else begin
                if (skip_first) begin
                    skip_first = 1'b0;
                end else if (exp_q.size() != 0) begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(cur_ph == it.ph && run_len == it.len, it.req,
                          cur_ph * 1000 + run_len, it.ph * 1000 + it.len);
                end
                cur_ph = ph;
                run_len = 1;
            end
        end
    end

    task automatic wait_load_start();
        do @(negedge clk); while (dut_reset);
        check(page_sel == cur_page, "R8", page_sel, cur_page);
        dut_addr = 32'hFFFF_FFF0;
        #1 check(mem_addr == {cur_page, 8'hFC}, "R7", mem_addr, {cur_page, 8'hFC});
        dut_addr = 32'h0000_0008;
        #1 check(mem_addr == {cur_page, 8'h02}, "R7", mem_addr, {cur_page, 8'h02});
    endtask

    // LOAD with ack after d idle cycles, then soak probing; s >= 2
    task automatic load_and_soak(input int d, input logic [6:0] new_page);
        if (d > 0) begin
            readback_strobe = 1'b1;   // R9: stray strobe in LOAD
            @(negedge clk);
            readback_strobe = 1'b0;
            repeat (d - 1) @(negedge clk);
        end
        dut_shutdown_ack = 1'b1;
        @(negedge clk);
        dut_shutdown_ack = 1'b1;      // R9: stray ack during SOAK
        mem_rdata = 32'h1234_5678;
        #1 check(halt_active == 1'b1, "R2", halt_active, 1);
        check(dut_rdata == 32'hF4F4_F4F4, "R4", dut_rdata, 32'hF4F4_F4F4);
        @(negedge clk);
        dut_shutdown_ack = 1'b0;
        cfg_test_page = new_page;
        do @(negedge clk); while (!dut_nmi);
        check(page_sel == cur_page, "R8", page_sel, cur_page);
        #1 check(dut_rdata == 32'h1234_5678, "R4", dut_rdata, 32'h1234_5678);
        do @(negedge clk); while (dut_nmi);
    endtask

    task automatic good_cycle(input int d, input int s, input int e, input int t,
                              input logic [6:0] new_page);
        cfg_soak_cycles = 24'(s);
        cfg_ack_timeout = 24'(t);
        push(P_IDLE, d + 1, "R2");
        push(P_SOAK, s + 1, "R4");
        push(P_IDLE, 1, "R5");
        push(P_NMI, 4, "R5");
        push(P_IDLE, e + 1, "R6");
        push(P_RST, 8, "R1");
        wait_load_start();
        load_and_soak(d, new_page);
        repeat (e) @(negedge clk);
        readback_strobe = 1'b1;
        @(negedge clk);
        readback_strobe = 1'b0;
        cur_page = new_page;
    endtask

    task automatic abort_load(input int t);
        cfg_ack_timeout = 24'(t);
        push(P_IDLE, t + 1, "R3");
        push(P_ABORT, 1, "R3");
        push(P_RST, 8, "R1");
        @(negedge clk);
        dut_shutdown_ack = 1'b1;      // R9: stray ack during RESET
        @(negedge clk);
        dut_shutdown_ack = 1'b0;
        wait_load_start();
        do @(negedge clk); while (!timeout_pulse);
    endtask

    task automatic abort_readback(input int d, input int s, input int t);
        cfg_soak_cycles = 24'(s);
        cfg_ack_timeout = 24'(t);
        push(P_IDLE, d + 1, "R2");
        push(P_SOAK, s + 1, "R4");
        push(P_IDLE, 1, "R5");
        push(P_NMI, 4, "R5");
        push(P_IDLE, t + 1, "R6");
        push(P_ABORT, 1, "R3");
        push(P_RST, 8, "R1");
        wait_load_start();
        load_and_soak(d, cur_page);
        do @(negedge clk); while (!timeout_pulse);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dut_reset == 1'b1, "R1", dut_reset, 1);
        check({dut_nmi, halt_active, timeout_pulse} == 3'b000, "R1",
              {dut_nmi, halt_active, timeout_pulse}, 0);
        rst_n = 1'b1;
        good_cycle(0, 5, 0, 6, 7'h15);
        good_cycle(6, 37, 3, 6, 7'h15);   // R2: ack in last cycle of window
        abort_load(4);
        abort_readback(2, 3, 5);
        good_cycle(3, 2, 6, 9, 7'h7F);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R1", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule